// File: doc/BRIEF.md
# Register Writeback Aging Buffer

This block sits in front of a physical register file and collects every writeback result in a small ring of slots before that result reaches the register file. Each slot holds a live flag, a physical register tag and a data value. The register file is written only when a slot has to be reused for a newer result and its old value is still live. A value whose register is freed while it waits in the ring never reaches the register file, so no write energy is spent on it.

Operand reads look in the ring first. A hit returns the value at once and the register file is not touched. A miss tells the caller to read the register file in a following step. A writeback and a read of the same tag in the same cycle return the value being written. Slots are reused strictly oldest first. A slot whose value was freed still keeps its place in the order until it is reused, and reusing it produces no write.

Top module: `wb_age_buf`

## Requirements
- R1: After reset the ring is empty: every read misses, and no register-file write is requested until the ring has been filled again.
- R2: A writeback while fewer than DEPTH slots are occupied is stored in the ring and raises no register-file write.
- R3: A read whose tag is held live in the ring gives rd_hit=1, rd_miss=0 and the stored value on rd_data. When rd_valid is 0, both rd_hit and rd_miss are 0.
- R4: A read whose tag is not live in the ring, and is not being written back in the same cycle, gives rd_hit=0 and rd_miss=1.
- R5: A writeback while all DEPTH slots are occupied reuses the oldest slot in the same cycle. If that slot is live, rf_we=1 in that cycle with the slot's tag on rf_tag and its value on rf_data. The old value misses from the next cycle on, and occupancy stays at DEPTH.
- R6: A free request whose tag matches a live slot clears that slot from the next cycle on, so reads of the tag miss. When that slot is later reused, no register-file write is raised.
- R7: If the oldest slot is reused in the same cycle that its tag is freed, no register-file write is raised.
- R8: A writeback and a read of the same tag in the same cycle give rd_hit=1 with the new writeback value.
- R9: rf_we is 1 only in a cycle that has a writeback while all DEPTH slots are occupied.
- R10: A free request whose tag matches no live slot changes nothing: every live slot keeps hitting with its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wb_valid | input | 1 | Writeback result present |
| wb_tag | input | TAG_W | Physical register tag of the result |
| wb_data | input | DATA_W | Result value |
| free_valid | input | 1 | Register free request present |
| free_tag | input | TAG_W | Tag being freed |
| rd_valid | input | 1 | Operand lookup present |
| rd_tag | input | TAG_W | Tag being looked up |
| rd_hit | output | 1 | Lookup served from the ring |
| rd_miss | output | 1 | Lookup must go to the register file |
| rd_data | output | DATA_W | Value on a hit, zero otherwise |
| rf_we | output | 1 | Register-file write request for a reused live slot |
| rf_tag | output | TAG_W | Register-file write tag |
| rf_data | output | DATA_W | Register-file write value |

## Verification
The checks assume that renaming gives each tag at most one live slot at a time. A tag is freed before it is written again, and a tag is never freed and written in the same cycle. Under those rules tag matches are unique, so a freed head can be recognised by its tag alone. The stimulus writes tags 1 to 13 once each, frees only tags that are held or absent, and starts a second fill only after a reset. Lookups and frees are issued on ring positions that have a known age, so each expected eviction follows from counting writebacks.

// File: rtl/wab_pkg.sv
package wab_pkg;
    localparam int WAB_DEPTH  = 8;
    localparam int WAB_TAG_W  = 6;
    localparam int WAB_DATA_W = 32;
endpackage

// File: rtl/wab_match.sv
// Associative tag search over the ring; lowest matching slot wins.
module wab_match #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 6,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]            live_i,
    input  logic [DEPTH-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]            key_i,
    output logic                        hit_o,
    output logic [PTR_W-1:0]            idx_o
);
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = live_i[g] && (tags_i[g] == key_i);
    end

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o = 1'b1;
                idx_o = PTR_W'(i);
            end
        end
    end
endmodule

// File: rtl/wab_ring.sv
// Ring position arithmetic: insert slot, advanced head and full flag.
module wab_ring #(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [PTR_W-1:0] head_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [PTR_W-1:0] tail_o,
    output logic [PTR_W-1:0] head_inc_o,
    output logic             full_o
);
    localparam int SUM_W = CNT_W + 1;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(head_i) + SUM_W'(count_i);
        if (sum >= SUM_W'(DEPTH)) begin
            sum = sum - SUM_W'(DEPTH);
        end
        tail_o     = PTR_W'(sum);
        head_inc_o = (head_i == PTR_W'(DEPTH - 1)) ? '0 : head_i + 1'b1;
        full_o     = (count_i == CNT_W'(DEPTH));
    end
endmodule

// File: rtl/wb_age_buf.sv
module wb_age_buf
    import wab_pkg::*;
#(
    parameter int DEPTH  = WAB_DEPTH,
    parameter int TAG_W  = WAB_TAG_W,
    parameter int DATA_W = WAB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              free_valid,
    input  logic [TAG_W-1:0]  free_tag,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic              rd_miss,
    output logic [DATA_W-1:0] rd_data,
    output logic              rf_we,
    output logic [TAG_W-1:0]  rf_tag,
    output logic [DATA_W-1:0] rf_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]             live;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [PTR_W-1:0]             head;
        logic [CNT_W-1:0]             count;
    } ring_state_t;

    ring_state_t state_d, state_q;

    logic             rd_buf_hit, free_hit, full;
    logic [PTR_W-1:0] rd_idx, free_idx, tail, head_inc;
    logic             rd_bypass, free_head;
    logic [CNT_W-1:0] occ;

    assign occ = state_q.count;

    wab_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_rd_match (
        .live_i (state_q.live),
        .tags_i (state_q.tag),
        .key_i  (rd_tag),
        .hit_o  (rd_buf_hit),
        .idx_o  (rd_idx)
    );

    wab_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_free_match (
        .live_i (state_q.live),
        .tags_i (state_q.tag),
        .key_i  (free_tag),
        .hit_o  (free_hit),
        .idx_o  (free_idx)
    );

    wab_ring #(.DEPTH(DEPTH)) u_ring (
        .head_i     (state_q.head),
        .count_i    (state_q.count),
        .tail_o     (tail),
        .head_inc_o (head_inc),
        .full_o     (full)
    );

    always_comb begin
        state_d = state_q;

        // Lookup path: same-cycle writeback has priority over the ring.
        rd_bypass = rd_valid && wb_valid && (wb_tag == rd_tag);
        rd_hit    = rd_valid && (rd_bypass || rd_buf_hit);
        rd_miss   = rd_valid && !rd_hit;
        if (rd_bypass) begin
            rd_data = wb_data;
        end else if (rd_valid && rd_buf_hit) begin
            rd_data = state_q.data[rd_idx];
        end else begin
            rd_data = '0;
        end

        // Eviction path: only a live oldest slot reaches the register file.
        free_head = free_valid && free_hit && (free_idx == state_q.head);
        rf_we     = wb_valid && full && state_q.live[state_q.head] && !free_head;
        rf_tag    = state_q.tag[state_q.head];
        rf_data   = state_q.data[state_q.head];

        // Free clears first, then a writeback may claim the slot.
        if (free_valid && free_hit) begin
            state_d.live[free_idx] = 1'b0;
        end
        if (wb_valid) begin
            state_d.live[tail] = 1'b1;
            state_d.tag[tail]  = wb_tag;
            state_d.data[tail] = wb_data;
            if (full) begin
                state_d.head = head_inc;
            end else begin
                state_d.count = state_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/wab_checker.sv
module wab_checker #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wb_valid,
    input logic [TAG_W-1:0]  wb_tag,
    input logic [DATA_W-1:0] wb_data,
    input logic              free_valid,
    input logic [TAG_W-1:0]  free_tag,
    input logic              rd_valid,
    input logic [TAG_W-1:0]  rd_tag,
    input logic              rd_hit,
    input logic              rd_miss,
    input logic [DATA_W-1:0] rd_data,
    input logic              rf_we,
    input logic [TAG_W-1:0]  rf_tag,
    input logic [CNT_W-1:0]  occ
);
    assert_evict_needs_full_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (wb_valid && occ == CNT_W'(DEPTH)));

    assert_no_write_with_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && occ < CNT_W'(DEPTH)) |-> !rf_we);

    assert_same_cycle_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && wb_valid && rd_tag == wb_tag) |-> (rd_hit && rd_data == wb_data));

    assert_freed_head_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !(free_valid && free_tag == rf_tag));

    assert_full_stays_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && occ == CNT_W'(DEPTH)) |=> (occ == CNT_W'(DEPTH)));

    assert_hit_miss_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_hit, rd_miss}) && ((rd_hit || rd_miss) == rd_valid));

    assert_occ_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));
endmodule

bind wb_age_buf wab_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .free_valid(free_valid), .free_tag(free_tag), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_hit(rd_hit), .rd_miss(rd_miss), .rd_data(rd_data), .rf_we(rf_we),
    .rf_tag(rf_tag), .occ(occ)
);

// File: tb/sim_wb_age_buf.sv
module sim_wb_age_buf;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int TW = 6;
    localparam int DW = 32;

    typedef struct packed {
        logic          wv;
        logic [TW-1:0] wt;
        logic [DW-1:0] wd;
        logic          fv;
        logic [TW-1:0] ft;
        logic          rv;
        logic [TW-1:0] rt;
        logic          eh;
        logic [DW-1:0] ed;
        logic          ew;
        logic [TW-1:0] et;
        logic [DW-1:0] edat;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'd0,  32'h0,   1'b0, 6'd0,  1'b1, 6'd5,  1'b0, 32'h0,   1'b0, 6'd0, 32'h0,   8'd1},  // R1 empty
        '{1'b1, 6'd1,  32'h101, 1'b0, 6'd0,  1'b1, 6'd1,  1'b1, 32'h101, 1'b0, 6'd0, 32'h0,   8'd8},  // R8 R2
        '{1'b1, 6'd2,  32'h102, 1'b0, 6'd0,  1'b1, 6'd2,  1'b1, 32'h102, 1'b0, 6'd0, 32'h0,   8'd8},
        '{1'b1, 6'd3,  32'h103, 1'b0, 6'd0,  1'b1, 6'd3,  1'b1, 32'h103, 1'b0, 6'd0, 32'h0,   8'd8},
        '{1'b1, 6'd4,  32'h104, 1'b0, 6'd0,  1'b1, 6'd4,  1'b1, 32'h104, 1'b0, 6'd0, 32'h0,   8'd8},
        '{1'b1, 6'd5,  32'h105, 1'b0, 6'd0,  1'b1, 6'd5,  1'b1, 32'h105, 1'b0, 6'd0, 32'h0,   8'd2},
        '{1'b1, 6'd6,  32'h106, 1'b0, 6'd0,  1'b1, 6'd6,  1'b1, 32'h106, 1'b0, 6'd0, 32'h0,   8'd2},
        '{1'b1, 6'd7,  32'h107, 1'b0, 6'd0,  1'b1, 6'd7,  1'b1, 32'h107, 1'b0, 6'd0, 32'h0,   8'd2},
        '{1'b1, 6'd8,  32'h108, 1'b0, 6'd0,  1'b1, 6'd8,  1'b1, 32'h108, 1'b0, 6'd0, 32'h0,   8'd2},  // R2 last free slot
        '{1'b0, 6'd0,  32'h0,   1'b0, 6'd0,  1'b1, 6'd1,  1'b1, 32'h101, 1'b0, 6'd0, 32'h0,   8'd3},  // R3 oldest
        '{1'b0, 6'd0,  32'h0,   1'b0, 6'd0,  1'b1, 6'd8,  1'b1, 32'h108, 1'b0, 6'd0, 32'h0,   8'd3},  // R3 newest
        '{1'b0, 6'd0,  32'h0,   1'b0, 6'd0,  1'b1, 6'd20, 1'b0, 32'h0,   1'b0, 6'd0, 32'h0,   8'd4},  // R4 absent
        '{1'b0, 6'd0,  32'h0,   1'b1, 6'd3,  1'b1, 6'd3,  1'b1, 32'h103, 1'b0, 6'd0, 32'h0,   8'd6},  // R6 free lands next cycle
        '{1'b0, 6'd0,  32'h0,   1'b0, 6'd0,  1'b1, 6'd3,  1'b0, 32'h0,   1'b0, 6'd0, 32'h0,   8'd6},  // R6 freed misses
        '{1'b0, 6'd0,  32'h0,   1'b1, 6'd40, 1'b1, 6'd2,  1'b1, 32'h102, 1'b0, 6'd0, 32'h0,   8'd10}, // R10 absent free
        '{1'b1, 6'd9,  32'h109, 1'b0, 6'd0,  1'b1, 6'd1,  1'b1, 32'h101, 1'b1, 6'd1, 32'h101, 8'd5},  // R5 evict tag 1
        '{1'b1, 6'd10, 32'h10A, 1'b0, 6'd0,  1'b1, 6'd1,  1'b0, 32'h0,   1'b1, 6'd2, 32'h102, 8'd5},  // R5 evict tag 2
        '{1'b1, 6'd11, 32'h10B, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 32'h0,   1'b0, 6'd0, 32'h0,   8'd6},  // R6 freed slot silent
        '{1'b1, 6'd12, 32'h10C, 1'b1, 6'd4,  1'b0, 6'd0,  1'b0, 32'h0,   1'b0, 6'd0, 32'h0,   8'd7},  // R7 free at eviction
        '{1'b1, 6'd13, 32'h10D, 1'b0, 6'd0,  1'b1, 6'd4,  1'b0, 32'h0,   1'b1, 6'd5, 32'h105, 8'd5},  // R5 evict tag 5
        '{1'b0, 6'd0,  32'h0,   1'b0, 6'd0,  1'b1, 6'd9,  1'b1, 32'h109, 1'b0, 6'd0, 32'h0,   8'd9},  // R9 idle
        '{1'b0, 6'd0,  32'h0,   1'b0, 6'd0,  1'b1, 6'd6,  1'b1, 32'h106, 1'b0, 6'd0, 32'h0,   8'd10}, // R10 kept
        '{1'b0, 6'd0,  32'h0,   1'b0, 6'd0,  1'b1, 6'd7,  1'b1, 32'h107, 1'b0, 6'd0, 32'h0,   8'd10}  // R10 kept
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wb_valid = 1'b0, free_valid = 1'b0, rd_valid = 1'b0;
    logic [TW-1:0] wb_tag = '0, free_tag = '0, rd_tag = '0;
    logic [DW-1:0] wb_data = '0;
    logic          rd_hit, rd_miss, rf_we;
    logic [DW-1:0] rd_data, rf_data;
    logic [TW-1:0] rf_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wb_age_buf #(.DEPTH(DEPTH), .TAG_W(TW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .free_valid(free_valid), .free_tag(free_tag), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .rd_hit(rd_hit), .rd_miss(rd_miss), .rd_data(rd_data),
        .rf_we(rf_we), .rf_tag(rf_tag), .rf_data(rf_data)
    );

    task automatic chk(input string what, input int req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply_and_check(input vec_t v);
        @(negedge clk);
        wb_valid = v.wv; wb_tag = v.wt; wb_data = v.wd;
        free_valid = v.fv; free_tag = v.ft;
        rd_valid = v.rv; rd_tag = v.rt;
        #1;
        chk("rd_hit", v.req, DW'(rd_hit), DW'(v.eh));
        chk("rd_miss", v.req, DW'(rd_miss), DW'(v.rv && !v.eh));
        if (v.eh) chk("rd_data", v.req, rd_data, v.ed);
        chk("rf_we", v.req, DW'(rf_we), DW'(v.ew));
        if (v.ew) begin
            chk("rf_tag", v.req, DW'(rf_tag), DW'(v.et));
            chk("rf_data", v.req, rf_data, v.edat);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply_and_check(VEC[i]);
        end

        // R1: reset mid-run empties the ring
        @(negedge clk);
        wb_valid = 1'b0; free_valid = 1'b0; rd_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        apply_and_check('{1'b0, 6'd0, 32'h0, 1'b0, 6'd0, 1'b1, 6'd9, 1'b0, 32'h0,
                          1'b0, 6'd0, 32'h0, 8'd1});
        apply_and_check('{1'b0, 6'd0, 32'h0, 1'b0, 6'd0, 1'b1, 6'd7, 1'b0, 32'h0,
                          1'b0, 6'd0, 32'h0, 8'd1});
        // R2, R8: refill after reset, new tags 21..28
        for (int t = 21; t < 21 + DEPTH; t++) begin
            apply_and_check('{1'b1, TW'(t), DW'(32'h200 + t), 1'b0, 6'd0, 1'b1, TW'(t), 1'b1,
                              DW'(32'h200 + t), 1'b0, 6'd0, 32'h0, 8'd2});
        end
        // R5: next writeback evicts the first post-reset entry
        apply_and_check('{1'b1, 6'd30, 32'h230, 1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 32'h0,
                          1'b1, 6'd21, 32'h215, 8'd5});
        // R4: evicted tag now misses
        apply_and_check('{1'b0, 6'd0, 32'h0, 1'b0, 6'd0, 1'b1, 6'd21, 1'b0, 32'h0,
                          1'b0, 6'd0, 32'h0, 8'd4});
        // R3: lookup idle gives neither flag
        apply_and_check('{1'b0, 6'd0, 32'h0, 1'b0, 6'd0, 1'b0, 6'd22, 1'b0, 32'h0,
                          1'b0, 6'd0, 32'h0, 8'd3});

        @(negedge clk);
        wb_valid = 1'b0; free_valid = 1'b0; rd_valid = 1'b0;
        finish_run();
    end
endmodule